// File: doc/BRIEF.md
# Background Tile Fetcher

This block is the sequencer that feeds a tile-based video pipeline with background and window graphics. It advances once per pixel clock. It reads a tile number from one of two tile maps, forms the address of the pattern row that belongs to the current scan line, and reads the two bitplane bytes of that row. It then offers the 8-pixel row to a downstream pixel queue. Every memory access takes two cycles: one cycle to set up the address and one cycle to capture the returned byte. A full pass through the block therefore takes seven states.

Per-tile attribute bits travel with the tile number. One bit selects the upper half of video memory (the second bank), and the other bit mirrors the tile vertically. The tile-data addressing mode is either unsigned or signed-with-bias. It is sampled at each address-setup step and held for the read that follows. When the window starts during the high-plane read, the block drops the current row and restarts from the map step. In window mode the column comes from an internal counter that steps with each delivered row and is cleared at the start of every line.

Top module: `bg_tile_fetcher`

## Requirements
- R1: With `push_ready` low, a pass runs in this order: map setup, map read, low setup, low read, high setup, high read, push. `vram_rd` is high only in the three read states. `push_valid` rises exactly 6 clocks after the first setup cycle that follows reset.
- R2: The tile-map base is 0x1800. It is 0x1C00 when either of these holds: `bg_map_hi`=1 with `win_active`=0, or `win_map_hi`=1 with `win_active`=1.
- R3: In background mode the map address is base + x + (line_y/8)*32, where x = ((scroll_x + fetch_pos + 8)/8) mod 32, computed with 8-bit wraparound.
- R4: With `tile_mode_unsigned`=1, the row address is tile*16 + row*2.
- R5: With `tile_mode_unsigned`=0, the row address is signed(tile)*16 + 0x1000 + row*2. For example, tile 0x80 gives 0x0800 and tile 0x7F gives 0x17F0.
- R6: `attr_bank`=1, captured with the tile number, adds 0x2000 to both plane addresses. This sets address bit 13.
- R7: `attr_flip`=1 selects row = (line_y mod 8) XOR 7. Otherwise row = line_y mod 8.
- R8: The high-plane address is the low-plane address plus 1. `push_lo` and `push_hi` present the bytes read at those two addresses.
- R9: The addressing mode is sampled in each address-setup cycle. A change of `tile_mode_unsigned` during a read cycle does not affect that read's address.
- R10: If `win_active` goes from 0 to 1 during the high-plane read, the next state is map setup. No push occurs for that row.
- R11: While `push_valid`=1 and `push_ready`=0, the block holds: `push_lo` and `push_hi` stay stable and no read is issued. After an accepted push, the next cycle is map setup.
- R12: In window mode, x is taken from a column counter. The counter steps by one on each accepted push while `win_active`=1. `line_start` clears it, and the clear wins over a step in the same cycle.
- R13: A synchronous active-high `rst` puts the block in map setup with both plane registers at zero and `push_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| bg_map_hi | input | 1 | Background uses the upper tile map |
| win_map_hi | input | 1 | Window uses the upper tile map |
| tile_mode_unsigned | input | 1 | 1: unsigned tile numbering, 0: signed with bias |
| win_active | input | 1 | Window is being drawn on this line |
| line_start | input | 1 | Pulse at the start of a line; clears the window column |
| scroll_x | input | 8 | Horizontal scroll |
| line_y | input | 8 | Line number used for map row and pattern row |
| fetch_pos | input | 8 | Horizontal fetch position |
| vram_addr | output | 14 | Video memory address (valid in read states) |
| vram_rd | output | 1 | Read strobe; data is captured this cycle |
| vram_data | input | 8 | Byte returned for `vram_addr` |
| attr_bank | input | 1 | Attribute bank bit, captured with the tile number |
| attr_flip | input | 1 | Attribute vertical flip bit, captured with the tile number |
| push_valid | output | 1 | An 8-pixel row is on offer |
| push_ready | input | 1 | Queue accepts the row |
| push_lo | output | 8 | Low bitplane |
| push_hi | output | 8 | High bitplane |

## Verification
Two events can fall in the same cycle: an accepted push, which steps the window column, and a `line_start` pulse, which clears it. The bench raises `line_start` on the same cycle as `push_ready` during a window push. It judges the result from the map address of the following pass, which must use column 0 and not the stepped value. A second collision is covered by raising `win_active` exactly in the high-plane read cycle. The bench confirms that no push appears and that the restarted pass addresses the window map.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
    localparam int VA_W   = 14;
    localparam int BYTE_W = 8;
    localparam int COL_W  = 5;
    localparam int ROW_W  = 3;
    localparam int TB_W   = VA_W - 1;

    typedef enum logic [2:0] {
        S_MAP_A  = 3'd0,
        S_MAP_RD = 3'd1,
        S_LO_A   = 3'd2,
        S_LO_RD  = 3'd3,
        S_HI_A   = 3'd4,
        S_HI_RD  = 3'd5,
        S_PUSH   = 3'd6
    } fstate_e;

    typedef struct packed {
        fstate_e           st;
        logic [VA_W-1:0]   map_addr;
        logic [BYTE_W-1:0] tile;
        logic              bank;
        logic              flip;
        logic              mode_u;
        logic [ROW_W-1:0]  row;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              win_prev;
    } fetch_regs_t;
endpackage

// File: rtl/bgf_map_addr.sv
module bgf_map_addr
    import bgf_pkg::*;
#(
    parameter logic [VA_W-1:0] MAP_BASE_LO = 14'h1800,
    parameter logic [VA_W-1:0] MAP_BASE_HI = 14'h1C00
) (
    input  logic              bg_map_hi,
    input  logic              win_map_hi,
    input  logic              win_mode,
    input  logic [BYTE_W-1:0] scroll_x,
    input  logic [BYTE_W-1:0] fetch_pos,
    input  logic [4:0]        y_group,
    input  logic [COL_W-1:0]  win_col,
    output logic [VA_W-1:0]   map_addr
);
    logic             use_hi;
    logic [COL_W-1:0] bg_col;
    logic [COL_W-1:0] col;

    always_comb begin
        use_hi   = win_mode ? win_map_hi : bg_map_hi;
        bg_col   = COL_W'((scroll_x + fetch_pos + BYTE_W'(8)) >> 3);
        col      = win_mode ? win_col : bg_col;
        map_addr = (use_hi ? MAP_BASE_HI : MAP_BASE_LO)
                 + VA_W'({y_group, col});
    end
endmodule

// File: rtl/bgf_data_addr.sv
module bgf_data_addr
    import bgf_pkg::*;
#(
    parameter logic [TB_W-1:0] SIGNED_BIAS = 13'h1000
) (
    input  logic [BYTE_W-1:0] tile,
    input  logic              bank,
    input  logic              mode_u,
    input  logic [ROW_W-1:0]  row,
    input  logic              plane_hi,
    output logic [VA_W-1:0]   addr
);
    logic [TB_W-1:0] base;

    always_comb begin
        if (mode_u) begin
            base = {1'b0, tile, 4'b0000};
        end else begin
            base = {tile[BYTE_W-1], tile, 4'b0000} + SIGNED_BIAS;
        end
        addr = {bank, base + TB_W'({row, plane_hi})};
    end
endmodule

// File: rtl/bgf_win_col.sv
module bgf_win_col
    import bgf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] col_d, col_q;

    always_comb begin
        col_d = col_q;
        if (clear) begin
            col_d = '0;
        end else if (step) begin
            col_d = col_q + COL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) col_q <= '0;
        else     col_q <= col_d;
    end

    assign col = col_q;
endmodule

// File: rtl/bg_tile_fetcher.sv
module bg_tile_fetcher
    import bgf_pkg::*;
#(
    parameter logic [VA_W-1:0] MAP_BASE_LO = 14'h1800,
    parameter logic [VA_W-1:0] MAP_BASE_HI = 14'h1C00,
    parameter logic [TB_W-1:0] SIGNED_BIAS = 13'h1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bg_map_hi,
    input  logic              win_map_hi,
    input  logic              tile_mode_unsigned,
    input  logic              win_active,
    input  logic              line_start,
    input  logic [BYTE_W-1:0] scroll_x,
    input  logic [BYTE_W-1:0] line_y,
    input  logic [BYTE_W-1:0] fetch_pos,
    output logic [VA_W-1:0]   vram_addr,
    output logic              vram_rd,
    input  logic [BYTE_W-1:0] vram_data,
    input  logic              attr_bank,
    input  logic              attr_flip,
    output logic              push_valid,
    input  logic              push_ready,
    output logic [BYTE_W-1:0] push_lo,
    output logic [BYTE_W-1:0] push_hi
);
    fetch_regs_t      r_d, r_q;
    logic [VA_W-1:0]  map_addr_c;
    logic [VA_W-1:0]  data_addr_c;
    logic [COL_W-1:0] win_col;
    logic             accept;
    logic             win_rise;
    logic [ROW_W-1:0] row_c;
    fstate_e          cur_st;

    assign cur_st   = r_q.st;
    assign accept   = (r_q.st == S_PUSH) && push_ready;
    assign win_rise = win_active && !r_q.win_prev;

    bgf_map_addr #(
        .MAP_BASE_LO(MAP_BASE_LO),
        .MAP_BASE_HI(MAP_BASE_HI)
    ) u_map (
        .bg_map_hi (bg_map_hi),
        .win_map_hi(win_map_hi),
        .win_mode  (win_active),
        .scroll_x  (scroll_x),
        .fetch_pos (fetch_pos),
        .y_group   (line_y[7:3]),
        .win_col   (win_col),
        .map_addr  (map_addr_c)
    );

    bgf_data_addr #(
        .SIGNED_BIAS(SIGNED_BIAS)
    ) u_dat (
        .tile    (r_q.tile),
        .bank    (r_q.bank),
        .mode_u  (r_q.mode_u),
        .row     (r_q.row),
        .plane_hi(r_q.st == S_HI_RD),
        .addr    (data_addr_c)
    );

    bgf_win_col u_col (
        .clk  (clk),
        .rst  (rst),
        .clear(line_start),
        .step (accept && win_active),
        .col  (win_col)
    );

    always_comb begin
        row_c      = line_y[2:0] ^ {ROW_W{r_q.flip}};
        r_d        = r_q;
        r_d.win_prev = win_active;
        unique case (r_q.st)
            S_MAP_A: begin
                r_d.map_addr = map_addr_c;
                r_d.st       = S_MAP_RD;
            end
            S_MAP_RD: begin
                r_d.tile = vram_data;
                r_d.bank = attr_bank;
                r_d.flip = attr_flip;
                r_d.st   = S_LO_A;
            end
            S_LO_A: begin
                r_d.mode_u = tile_mode_unsigned;
                r_d.row    = row_c;
                r_d.st     = S_LO_RD;
            end
            S_LO_RD: begin
                r_d.lo = vram_data;
                r_d.st = S_HI_A;
            end
            S_HI_A: begin
                r_d.mode_u = tile_mode_unsigned;
                r_d.row    = row_c;
                r_d.st     = S_HI_RD;
            end
            S_HI_RD: begin
                if (win_rise) begin
                    r_d.st = S_MAP_A;
                end else begin
                    r_d.hi = vram_data;
                    r_d.st = S_PUSH;
                end
            end
            S_PUSH: begin
                if (push_ready) r_d.st = S_MAP_A;
            end
            default: r_d.st = S_MAP_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q          <= '0;
            r_q.st       <= S_MAP_A;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        vram_rd   = 1'b0;
        vram_addr = '0;
        unique case (r_q.st)
            S_MAP_RD: begin
                vram_rd   = 1'b1;
                vram_addr = r_q.map_addr;
            end
            S_LO_RD, S_HI_RD: begin
                vram_rd   = 1'b1;
                vram_addr = data_addr_c;
            end
            default: ;
        endcase
    end

    assign push_valid = (r_q.st == S_PUSH);
    assign push_lo    = r_q.lo;
    assign push_hi    = r_q.hi;
endmodule

// File: rtl/bgf_checker.sv
module bgf_checker
    import bgf_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [2:0]      st,
    input logic            win_active,
    input logic            vram_rd,
    input logic [VA_W-1:0] vram_addr,
    input logic            push_valid,
    input logic            push_ready,
    input logic [7:0]      push_lo,
    input logic [7:0]      push_hi
);
    // R1: setup and read steps advance one state per clock
    a_r1_step_order: assert property (@(posedge clk) disable iff (rst)
        (st == S_MAP_A || st == S_MAP_RD || st == S_LO_A || st == S_LO_RD || st == S_HI_A)
        |=> (st == 3'($past(st) + 3'd1)));

    // R1: reads never fall in two adjacent cycles
    a_r1_read_spacing: assert property (@(posedge clk) disable iff (rst)
        vram_rd |=> !vram_rd);

    // R8: plane parity of the data addresses
    a_r8_lo_even: assert property (@(posedge clk) disable iff (rst)
        (st == S_LO_RD) |-> !vram_addr[0]);
    a_r8_hi_odd: assert property (@(posedge clk) disable iff (rst)
        (st == S_HI_RD) |-> vram_addr[0]);

    // R10: window start in high read restarts the pass
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        (st == S_HI_RD && win_active && !$past(win_active)) |=> (st == S_MAP_A));

    // R11: offered row holds while not accepted
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (push_valid && !push_ready) |=> (push_valid && $stable(push_lo) && $stable(push_hi)));

    // R11: accepted row returns to map setup
    a_r11_return: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_ready) |=> (st == S_MAP_A && !push_valid));
endmodule

bind bg_tile_fetcher bgf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .st        (cur_st),
    .win_active(win_active),
    .vram_rd   (vram_rd),
    .vram_addr (vram_addr),
    .push_valid(push_valid),
    .push_ready(push_ready),
    .push_lo   (push_lo),
    .push_hi   (push_hi)
);

// File: tb/bg_tile_fetcher_bench.sv
module bg_tile_fetcher_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bg_map_hi = 1'b0, win_map_hi = 1'b0, tile_mode_unsigned = 1'b1;
    logic        win_active = 1'b0, line_start = 1'b0;
    logic [7:0]  scroll_x = '0, line_y = '0, fetch_pos = '0;
    logic [13:0] vram_addr;
    logic        vram_rd;
    logic [7:0]  vram_data;
    logic        attr_bank = 1'b0, attr_flip = 1'b0;
    logic        push_valid, push_ready = 1'b0;
    logic [7:0]  push_lo, push_hi;
    logic [7:0]  tile_val = '0;

    int errors = 0;
    int checks = 0;
    logic [13:0] rd_log [0:15];
    int rd_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bg_tile_fetcher u_bg_tile_fetcher (
        .clk(clk), .rst(rst), .bg_map_hi(bg_map_hi), .win_map_hi(win_map_hi),
        .tile_mode_unsigned(tile_mode_unsigned), .win_active(win_active),
        .line_start(line_start), .scroll_x(scroll_x), .line_y(line_y),
        .fetch_pos(fetch_pos), .vram_addr(vram_addr), .vram_rd(vram_rd),
        .vram_data(vram_data), .attr_bank(attr_bank), .attr_flip(attr_flip),
        .push_valid(push_valid), .push_ready(push_ready),
        .push_lo(push_lo), .push_hi(push_hi)
    );

    function automatic logic [7:0] pat(input logic [13:0] a);
        return a[7:0] ^ {2'b01, a[13:8]};
    endfunction

    assign vram_data = (vram_addr >= 14'h1800 && vram_addr < 14'h2000) ? tile_val : pat(vram_addr);

    always @(negedge clk) begin
        #1;
        if (!rst && vram_rd && rd_n < 16) begin
            rd_log[rd_n] = vram_addr;
            rd_n++;
        end
    end

    function automatic logic [13:0] e_map(input bit win, input int col);
        int base, x;
        base = ((win ? win_map_hi : bg_map_hi) != 0) ? 'h1C00 : 'h1800;
        x    = win ? (col % 32) : ((((scroll_x + fetch_pos + 8) % 256) / 8) % 32);
        return 14'(base + x + (line_y / 8) * 32);
    endfunction

    function automatic logic [13:0] e_lo(input logic [7:0] t, input bit bank, input bit flip, input bit uns);
        int base, row;
        base = uns ? int'(t) * 16 : int'($signed(t)) * 16 + 'h1000;
        row  = (line_y % 8) ^ (flip ? 7 : 0);
        return 14'((bank ? 'h2000 : 0) + base + row * 2);
    endfunction

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; push_ready = 1'b0; line_start = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        rd_n = 0;
    endtask

    task automatic wait_push(input string req, output int n);
        n = 0;
        while (n < 40) begin
            @(negedge clk); #2; n++;
            if (push_valid) break;
        end
        chk({req, " push arrives"}, int'(push_valid), 1);
    endtask

    task automatic accept_push();
        push_ready = 1'b1;
        @(negedge clk);
        push_ready = 1'b0;
        rd_n = 0;
    endtask

    task automatic run_one(input string req, input logic [13:0] emap, input logic [13:0] elo, input logic [13:0] ehi);
        int n;
        do_reset();
        wait_push(req, n);
        chk({req, " map addr"}, int'(rd_log[0]), int'(emap));
        chk({req, " low addr"}, int'(rd_log[1]), int'(elo));
        chk({req, " high addr"}, int'(rd_log[2]), int'(ehi));
        chk({req, " low data"}, int'(push_lo), int'(pat(elo)));
        chk({req, " high data"}, int'(push_hi), int'(pat(ehi)));
        accept_push();
    endtask

    task automatic t_reset_r13();
        do_reset(); #2;
        chk("R13 valid after reset", int'(push_valid), 0);
        chk("R13 low plane cleared", int'(push_lo), 0);
        chk("R13 high plane cleared", int'(push_hi), 0);
        chk("R13 no read in map setup", int'(vram_rd), 0);
    endtask

    task automatic t_order_r1();
        bg_map_hi = 0; win_active = 0; tile_mode_unsigned = 1;
        scroll_x = 8'd13; fetch_pos = 8'd20; line_y = 8'd45; tile_val = 8'h3C;
        attr_bank = 0; attr_flip = 0;
        do_reset();
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk); #2;
            chk($sformatf("R1 read strobe step %0d", k), int'(vram_rd), (k % 2));
            chk($sformatf("R1 push strobe step %0d", k), int'(push_valid), (k == 6) ? 1 : 0);
        end
        chk("R1 three reads per pass", rd_n, 3);
        chk("R8 high follows low", int'(rd_log[2]), int'(rd_log[1]) + 1);
        accept_push();
    endtask

    task automatic t_map_r2_r3();
        win_active = 0; tile_mode_unsigned = 1; tile_val = 8'h10;
        bg_map_hi = 1; win_map_hi = 0;
        scroll_x = 8'd250; fetch_pos = 8'd10; line_y = 8'd200;
        run_one("R2 R3 upper bg map wrap", e_map(0, 0), e_lo(8'h10, 0, 0, 1), e_lo(8'h10, 0, 0, 1) + 1);
        bg_map_hi = 0; win_map_hi = 1;
        scroll_x = 8'd7; fetch_pos = 8'd100; line_y = 8'd9;
        run_one("R2 R3 window bit ignored in bg", e_map(0, 0), e_lo(8'h10, 0, 0, 1), e_lo(8'h10, 0, 0, 1) + 1);
        chk("R2 lower base", int'(rd_log[0]) < 'h1C00 ? 1 : 0, 1);
    endtask

    task automatic t_modes_r4_r5();
        scroll_x = 0; fetch_pos = 0; line_y = 8'd5; bg_map_hi = 0; win_active = 0;
        tile_mode_unsigned = 1; tile_val = 8'hF3;
        run_one("R4 unsigned tile", e_map(0, 0), 14'h0F3A, 14'h0F3B);
        tile_mode_unsigned = 0; tile_val = 8'h80;
        run_one("R5 signed tile 0x80", e_map(0, 0), 14'h080A, 14'h080B);
        tile_val = 8'h7F;
        run_one("R5 signed tile 0x7F", e_map(0, 0), 14'h17FA, 14'h17FB);
    endtask

    task automatic t_attr_r6_r7();
        tile_mode_unsigned = 1; tile_val = 8'h22; line_y = 8'd2;
        attr_bank = 1; attr_flip = 0;
        run_one("R6 bank bit", e_map(0, 0), 14'h2224, 14'h2225);
        attr_bank = 0; attr_flip = 1;
        run_one("R7 vertical flip", e_map(0, 0), 14'h022A, 14'h022B);
        attr_flip = 0;
    endtask

    task automatic t_latch_r9();
        int n;
        tile_val = 8'h05; line_y = 8'd3; tile_mode_unsigned = 1;
        do_reset();
        repeat (3) @(negedge clk);
        tile_mode_unsigned = 0;
        #2;
        chk("R9 read addr unchanged by mode flip", int'(vram_addr), 14'h0056);
        wait_push("R9", n);
        chk("R9 high setup takes new mode", int'(rd_log[2]), 14'h1057);
        chk("R9 high data", int'(push_hi), int'(pat(14'h1057)));
        accept_push();
        tile_mode_unsigned = 1;
    endtask

    task automatic t_restart_r10();
        int n;
        bg_map_hi = 0; win_map_hi = 1; line_y = 8'd40; tile_val = 8'h01;
        do_reset();
        repeat (5) @(negedge clk);
        win_active = 1;
        @(negedge clk); #2;
        chk("R10 no push after restart", int'(push_valid), 0);
        chk("R10 back to map setup", int'(vram_rd), 0);
        wait_push("R10", n);
        chk("R10 restart pass length", n, 6);
        chk("R10 window map addr", int'(rd_log[3]), int'(e_map(1, 0)));
        accept_push();
        win_active = 0;
    endtask

    task automatic t_hold_r11();
        int n;
        logic [7:0] lo0, hi0;
        tile_val = 8'h44; line_y = 8'd6;
        do_reset();
        wait_push("R11", n);
        lo0 = push_lo; hi0 = push_hi;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #2;
            chk("R11 still offered", int'(push_valid), 1);
            chk("R11 low stable", int'(push_lo), int'(lo0));
            chk("R11 high stable", int'(push_hi), int'(hi0));
            chk("R11 no read while holding", int'(vram_rd), 0);
        end
        accept_push(); #2;
        chk("R11 map setup after accept", int'(vram_rd) + int'(push_valid), 0);
        @(negedge clk); #2;
        chk("R11 map read next", int'(vram_addr), int'(e_map(0, 0)));
    endtask

    task automatic t_window_r12();
        int n;
        win_active = 1; win_map_hi = 1; line_y = 8'd16; tile_val = 8'h02;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            wait_push("R12", n);
            chk($sformatf("R12 window column %0d", i), int'(rd_log[0]), int'(e_map(1, i)));
            if (i == 3) line_start = 1'b1;
            accept_push();
            line_start = 1'b0;
        end
        wait_push("R12", n);
        chk("R12 clear beats step", int'(rd_log[0]), int'(e_map(1, 0)));
        accept_push();
        win_active = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++; checks++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_r13();
        t_order_r1();
        t_map_r2_r3();
        t_modes_r4_r5();
        t_attr_r6_r7();
        t_latch_r9();
        t_restart_r10();
        t_hold_r11();
        t_window_r12();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule